// File: doc/BRIEF.md
# Four-Way LRU Data Cache Controller

This block is the control half of a 32-Kbyte, four-way set-associative data cache placed between a processor load/store port and a simple word-wide external memory port. Each way has 256 lines of 32 bytes. The controller keeps the tags, the valid bits, the dirty bits and a six-bit pairwise-age LRU word per set. The line data lives in a separate single-port word RAM that the controller addresses through its own data-RAM port. The set is selected by the index field of the address, and the line is matched against the stored tags of all four ways.

On a miss the controller chooses a victim way. An invalid way is taken first; otherwise it takes the least recently used way of the set. If the victim is dirty, it writes the victim's eight words back to memory. It then fills the whole line, word 0 first, and replays the access as a hit. A single input selects the store policy at run time. In copy-back mode stores allocate and only mark the line dirty. In write-through mode every store goes to memory, a hit also updates the line, and a store miss does not allocate. While a fill, a write-back or a write-through store is in progress, the processor sees a stall.

Top module: `dcache_ctrl`

## Requirements
- R1: After reset every line is invalid, so the first access to any address misses. With no access pending, `cpu_stall` is low and `mem_req` is low.
- R2: Address fields are: word select `cpu_addr[4:2]`, set index `cpu_addr[IDX_W+4:5]`, tag above the index. At most one way hits. A load hit returns the stored word in the same cycle without stall or memory traffic.
- R3: A load miss fills the line with exactly eight memory reads at ascending word addresses, starting at the line base. `cpu_stall` stays high throughout, and the load returns the value read from memory.
- R4: The victim is the lowest-numbered invalid way of the set. When all four ways are valid, the victim is the least recently used way.
- R5: Recency is updated on every hit and on every fill, so a hit protects its line from the next eviction.
- R6: With `wt_mode`=0 (copy-back), a store hit updates the cached word, marks the line dirty and causes no memory write.
- R7: With `wt_mode`=0, a store miss allocates: the line is filled and then written, with no memory write.
- R8: A dirty victim is written back as eight memory writes of its stored data before the first fill read. A clean victim causes no memory write.
- R9: With `wt_mode`=1 (write-through), each store is one memory write and completes on its acknowledge. A hit also updates the line without marking it dirty. A miss does not allocate.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wt_mode | input | 1 | Store policy: 1 write-through, 0 copy-back |
| cpu_req | input | 1 | Access request, held until not stalled |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | ADDR_W | Byte address (word aligned) |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when request completes |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write when high |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory word transfer done |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| dr_addr | output | IDX_W+5 | Data RAM address {way, set, word} |
| dr_we | output | 1 | Data RAM write enable |
| dr_wdata | output | 32 | Data RAM write data |
| dr_rdata | input | 32 | Data RAM read data (combinational) |

## Verification
The bench builds the controller with `IDX_W`=4, so there are 16 sets. With that setting, distinct tags that collide on one set are only 512 bytes apart. A small memory model and a 512-word data RAM then cover every line the bench touches. Filling all four ways of one set and then forcing evictions in a chosen recency order makes the pairwise-age victim choice visible at the memory port. The same setting also makes it easy to push a dirty line out, and to push out a line that was stored only under write-through.

// File: rtl/dcache_ctrl.sv
module dcache_ctrl #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 8,
  parameter int WORD_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wt_mode,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [31:0]               cpu_wdata,
  output logic [31:0]               cpu_rdata,
  output logic                      cpu_stall,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [31:0]               mem_wdata,
  input  logic                      mem_ack,
  input  logic [31:0]               mem_rdata,
  output logic [IDX_W+WORD_W+1:0]   dr_addr,
  output logic                      dr_we,
  output logic [31:0]               dr_wdata,
  input  logic [31:0]               dr_rdata
);
  localparam int SETS  = 1 << IDX_W;
  localparam int OFF_W = WORD_W + 2;
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam logic [WORD_W-1:0] LAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_WT} st_t;

  logic [TAG_W-1:0] tag_q [4][SETS];
  logic [SETS-1:0]  vld_q [4];
  logic [SETS-1:0]  dirty_q [4];
  logic [5:0]       lru_q [SETS];
  st_t              st_q;
  logic [1:0]       vic_q;
  logic [WORD_W-1:0] cnt_q;

  wire [IDX_W-1:0]  idx  = cpu_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  tag  = cpu_addr[ADDR_W-1 -: TAG_W];
  wire [WORD_W-1:0] word = cpu_addr[2 +: WORD_W];

  function automatic int pidx(int i, int j);
    if (i == 0) return j - 1;
    else if (i == 1) return j + 1;
    else return 5;
  endfunction

  function automatic logic [5:0] touch(logic [5:0] b, logic [1:0] w);
    logic [5:0] r;
    r = b;
    for (int j = 0; j < 4; j++) begin
      if (j < int'(w)) r[pidx(j, int'(w))] = 1'b0;
      else if (j > int'(w)) r[pidx(int'(w), j)] = 1'b1;
    end
    return r;
  endfunction

  logic [3:0] hit_vec, old_vec;
  logic       hit, any_inv;
  logic [1:0] hit_way, lru_way, inv_way, victim;
  logic [5:0] lru_cur;

  always_comb begin
    lru_cur = lru_q[idx];
    hit_way = '0;
    lru_way = '0;
    inv_way = '0;
    any_inv = 1'b0;
    for (int w = 0; w < 4; w++) begin
      hit_vec[w] = vld_q[w][idx] && (tag_q[w][idx] == tag);
      old_vec[w] = 1'b1;
      for (int j = 0; j < 4; j++) begin
        if (j > w) old_vec[w] = old_vec[w] & ~lru_cur[pidx(w, j)];
        else if (j < w) old_vec[w] = old_vec[w] & lru_cur[pidx(j, w)];
      end
    end
    for (int w = 3; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = 2'(w);
      if (old_vec[w]) lru_way = 2'(w);
      if (!vld_q[w][idx]) begin
        inv_way = 2'(w);
        any_inv = 1'b1;
      end
    end
    hit    = |hit_vec;
    victim = any_inv ? inv_way : lru_way;
  end

  wire idle_hit_ok = (st_q == S_IDLE) && cpu_req && hit && !(cpu_we && wt_mode);
  wire wt_done     = (st_q == S_WT) && mem_ack;
  wire fill_ack    = (st_q == S_FILL) && mem_ack;
  wire xfer_mode   = (st_q == S_WB) || (st_q == S_FILL);

  assign cpu_stall = cpu_req && !(idle_hit_ok || wt_done);
  assign cpu_rdata = dr_rdata;

  assign dr_addr  = xfer_mode ? {vic_q, idx, cnt_q} : {hit_way, idx, word};
  assign dr_we    = (idle_hit_ok && cpu_we) || (wt_done && hit) || fill_ack;
  assign dr_wdata = fill_ack ? mem_rdata : cpu_wdata;

  assign mem_req   = (st_q != S_IDLE);
  assign mem_we    = (st_q == S_WB) || (st_q == S_WT);
  assign mem_wdata = (st_q == S_WB) ? dr_rdata : cpu_wdata;

  always_comb begin
    case (st_q)
      S_WB:    mem_addr = {tag_q[vic_q][idx], idx, cnt_q, 2'b00};
      S_FILL:  mem_addr = {tag, idx, cnt_q, 2'b00};
      default: mem_addr = {cpu_addr[ADDR_W-1:2], 2'b00};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      vic_q <= '0;
      cnt_q <= '0;
      for (int w = 0; w < 4; w++) begin
        vld_q[w]   <= '0;
        dirty_q[w] <= '0;
      end
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (cpu_req) begin
          if (idle_hit_ok) begin
            lru_q[idx] <= touch(lru_cur, hit_way);
            if (cpu_we) dirty_q[hit_way][idx] <= 1'b1;
          end else if (cpu_we && wt_mode) begin
            st_q <= S_WT;
          end else begin
            vic_q <= victim;
            cnt_q <= '0;
            st_q  <= (vld_q[victim][idx] && dirty_q[victim][idx]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            dirty_q[vic_q][idx] <= 1'b0;
            st_q <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            tag_q[vic_q][idx]   <= tag;
            vld_q[vic_q][idx]   <= 1'b1;
            dirty_q[vic_q][idx] <= 1'b0;
            lru_q[idx]          <= touch(lru_cur, vic_q);
            st_q                <= S_IDLE;
          end
        end
        default: if (mem_ack) begin
          if (hit) lru_q[idx] <= touch(lru_cur, hit_way);
          st_q <= S_IDLE;
        end
      endcase
    end
  end

  AST_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !cpu_stall && !mem_req); // R1
  AST_ONE_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_FILL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> cpu_stall); // R3
  AST_FILL_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL) && mem_ack && (cnt_q != LAST) |=>
      mem_addr[2 +: WORD_W] == WORD_W'($past(mem_addr[2 +: WORD_W]) + 1'b1)); // R3
  AST_CLEAN_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_FILL) |-> !(vld_q[vic_q][idx] && dirty_q[vic_q][idx])); // R8
  AST_WT_STORE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_we && wt_mode && !cpu_stall |-> mem_req && mem_we && mem_ack); // R9
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10
endmodule

// File: tb/dcache_ctrl_tb_top.sv
`timescale 1ns/1ps
module dcache_ctrl_tb_top;
  localparam int IDX_W = 4;
  localparam int DRA_W = IDX_W + 5;

  logic clk = 0, rst_n = 0, wt_mode = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic cpu_stall, mem_req, mem_we, mem_ack = 0, dr_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, dr_wdata, dr_rdata;
  logic [DRA_W-1:0] dr_addr;

  logic [31:0] mem [0:4095];
  logic [31:0] refm [0:4095];
  logic [31:0] dram [0:(1<<DRA_W)-1];
  logic [31:0] rd_log [0:15];
  int rd_cnt, wr_cnt, wr_after_rd, hold_viol;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic prev_req = 0, prev_ack = 0;
  logic [31:0] prev_addr = '0;

  always #2.5 clk = ~clk;

  dcache_ctrl #(.ADDR_W(32), .IDX_W(IDX_W), .WORD_W(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dr_addr(dr_addr), .dr_we(dr_we), .dr_wdata(dr_wdata), .dr_rdata(dr_rdata));

  assign mem_rdata = mem[mem_addr[13:2]];
  assign dr_rdata  = dram[dr_addr];

  always @(posedge clk) begin
    if (dr_we) dram[dr_addr] <= dr_wdata;
    if (mem_req && prev_req && !prev_ack && mem_addr != prev_addr) hold_viol++;
    prev_req  <= mem_req;
    prev_ack  <= mem_ack;
    prev_addr <= mem_addr;
    if (mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt++;
        if (rd_cnt > 0) wr_after_rd++;
      end else begin
        if (rd_cnt < 16) rd_log[rd_cnt] = mem_addr;
        rd_cnt++;
      end
    end
    mem_ack <= mem_req && !mem_ack;
  end

  function automatic logic [31:0] ad(int t, int s, int w);
    return (t << 9) | (s << 5) | (w << 2);
  endfunction

  task automatic chk(input bit ok, input string req, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input [31:0] a, input [31:0] d,
                        output [31:0] rd, output int cyc);
    rd_cnt = 0; wr_cnt = 0; wr_after_rd = 0; cyc = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    #1;
    while (cpu_stall && cyc < 1000) begin
      @(negedge clk); #1; cyc++;
    end
    rd = cpu_rdata;
    @(posedge clk); #1;
    cpu_req = 0; cpu_we = 0;
    if (we) refm[a[13:2]] = d;
  endtask

  task automatic t_reset;
    logic [31:0] rd; int c;
    chk(cpu_stall == 0, "R1 stall after reset", 32'(cpu_stall), 0);
    chk(mem_req == 0, "R1 mem_req after reset", 32'(mem_req), 0);
    access(0, ad(1, 2, 3), 0, rd, c);
    chk(rd_cnt == 8, "R1 first access misses", rd_cnt, 8);
  endtask

  task automatic t_fill_hit;
    logic [31:0] rd; int c; bit ord;
    access(0, ad(2, 4, 5), 0, rd, c);
    chk(rd == refm[ad(2, 4, 5) >> 2], "R3 miss data", rd, refm[ad(2, 4, 5) >> 2]);
    chk(rd_cnt == 8 && c >= 8, "R3 eight reads with stall", rd_cnt, 8);
    ord = 1;
    for (int i = 0; i < 8; i++) if (rd_log[i] != ad(2, 4, i)) ord = 0;
    chk(ord, "R3 ascending fill order", rd_log[0], ad(2, 4, 0));
    access(0, ad(2, 4, 6), 0, rd, c);
    chk(rd == refm[ad(2, 4, 6) >> 2], "R2 hit data", rd, refm[ad(2, 4, 6) >> 2]);
    chk(rd_cnt == 0 && wr_cnt == 0 && c == 0, "R2 hit no stall no traffic", c, 0);
  endtask

  task automatic t_lru;
    logic [31:0] rd; int c; int hits;
    for (int t = 1; t <= 4; t++) access(0, ad(t, 3, 0), 0, rd, c);
    hits = 0;
    for (int t = 1; t <= 4; t++) begin
      access(0, ad(t, 3, 1), 0, rd, c);
      if (rd_cnt == 0) hits++;
    end
    chk(hits == 4, "R4 invalid ways used first", hits, 4);
    access(0, ad(1, 3, 2), 0, rd, c);
    access(0, ad(5, 3, 0), 0, rd, c);
    access(0, ad(1, 3, 0), 0, rd, c);
    chk(rd_cnt == 0, "R5 touched line survives", rd_cnt, 0);
    access(0, ad(2, 3, 0), 0, rd, c);
    chk(rd_cnt == 8, "R4 LRU line evicted", rd_cnt, 8);
    access(0, ad(4, 3, 0), 0, rd, c);
    chk(rd_cnt == 0, "R5 recent line kept", rd_cnt, 0);
    access(0, ad(3, 3, 0), 0, rd, c);
    chk(rd_cnt == 8, "R4 oldest evicted after hit", rd_cnt, 8);
    chk(rd == refm[ad(3, 3, 0) >> 2], "R4 refill data", rd, refm[ad(3, 3, 0) >> 2]);
  endtask

  task automatic t_copyback;
    logic [31:0] rd; int c; logic [31:0] a;
    a = ad(1, 5, 2);
    access(0, a, 0, rd, c);
    access(1, a, 32'hCAFE0001, rd, c);
    chk(wr_cnt == 0 && c == 0, "R6 store hit no mem write", wr_cnt, 0);
    chk(mem[a[13:2]] != 32'hCAFE0001, "R6 memory untouched", mem[a[13:2]], 0);
    access(0, a, 0, rd, c);
    chk(rd == 32'hCAFE0001, "R6 read back", rd, 32'hCAFE0001);
    for (int t = 2; t <= 4; t++) access(0, ad(t, 5, 0), 0, rd, c);
    access(0, ad(5, 5, 0), 0, rd, c);
    chk(wr_cnt == 8 && rd_cnt == 8, "R8 writeback then fill", wr_cnt, 8);
    chk(wr_after_rd == 0, "R8 writeback before fill", wr_after_rd, 0);
    chk(mem[a[13:2]] == 32'hCAFE0001, "R8 dirty data in memory", mem[a[13:2]], 32'hCAFE0001);
    chk(rd == refm[ad(5, 5, 0) >> 2], "R8 data after refill", rd, refm[ad(5, 5, 0) >> 2]);
    a = ad(1, 7, 4);
    access(1, a, 32'hBEEF0007, rd, c);
    chk(rd_cnt == 8 && wr_cnt == 0, "R7 store miss allocates", rd_cnt, 8);
    access(0, a, 0, rd, c);
    chk(rd == 32'hBEEF0007 && rd_cnt == 0, "R7 allocated line holds store", rd, 32'hBEEF0007);
  endtask

  task automatic t_wt;
    logic [31:0] rd; int c; logic [31:0] a, b;
    wt_mode = 1;
    a = ad(1, 9, 1);
    access(0, a, 0, rd, c);
    access(1, a, 32'h11112222, rd, c);
    chk(wr_cnt == 1 && rd_cnt == 0 && c > 0, "R9 store hit writes memory", wr_cnt, 1);
    chk(mem[a[13:2]] == 32'h11112222, "R9 memory updated", mem[a[13:2]], 32'h11112222);
    access(0, a, 0, rd, c);
    chk(rd == 32'h11112222 && rd_cnt == 0, "R9 line updated on hit", rd, 32'h11112222);
    b = ad(2, 9, 3);
    access(1, b, 32'h33334444, rd, c);
    chk(wr_cnt == 1 && rd_cnt == 0, "R9 store miss no fill", rd_cnt, 0);
    access(0, b, 0, rd, c);
    chk(rd_cnt == 8 && rd == 32'h33334444, "R9 store miss not allocated", rd_cnt, 8);
    wt_mode = 0;
    for (int t = 3; t <= 4; t++) access(0, ad(t, 9, 0), 0, rd, c);
    access(0, ad(5, 9, 0), 0, rd, c);
    chk(wr_cnt == 0 && rd_cnt == 8, "R9 wt-stored line evicted clean", wr_cnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin
      mem[i]  = 32'hA500_0000 ^ (i * 32'h0001_0101);
      refm[i] = mem[i];
    end
    for (int i = 0; i < (1 << DRA_W); i++) dram[i] = '0;
    rd_cnt = 0; wr_cnt = 0; wr_after_rd = 0; hold_viol = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    t_reset();
    t_fill_hit();
    t_lru();
    t_copyback();
    t_wt();
    chk(hold_viol == 0, "R10 memory request held until ack", hold_viol, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule